// File: doc/BRIEF.md
# Snoop retry response generator

This block sits inside a caching agent that watches a shared processor bus. Each time another master starts an address tenure, the block takes the result of a tag lookup for the snooped address. It then decides whether that tenure must be retried. A retry is forced when the address hits a dirty line that has to be written back first, or when the lookup reports that the snoop cannot be serviced. The lookup is a stub that returns its hit, dirty and busy flags a fixed number of cycles after the address start. When the retry is caused by a dirty hit, the block requests the bus in the cycle just after the qualified retry cycle. It then waits for a grant it is ready to accept, and emits a one-cycle push-start strobe that launches the copy-back tenure.

All bus signals are active-high at this boundary; pad-level inversion lives elsewhere. The lookup flags are valid in the same cycle as the address-start pulse. The system is assumed to give acknowledge no earlier than the decision cycle, `TS + max(1, LOOKUP_LAT)`, and to start no new tenure before the second cycle after an acknowledge.

Top module: `snoop_retry_gen`

## Requirements
- R1: A snooped tenure is retried (retry_o high at some point) exactly when, in its address-start cycle, look_busy_i=1 or (look_hit_i=1 and look_dirty_i=1). A miss or a clean hit leaves retry_o low.
- R2: For a retried tenure whose address start is in cycle T, retry_o first goes high in cycle T + max(2, LOOKUP_LAT+1) and never earlier. The default LOOKUP_LAT is 1, which gives T+2.
- R3: Once high, retry_o stays high up to and including the cycle after snp_aack_i, and is low in the cycle after that. When acknowledge comes in the decision cycle itself, retry_o is high only in the cycle after acknowledge.
- R4: A tenure retried for look_hit_i=1, look_dirty_i=1, look_busy_i=0 raises bus_req_o in the cycle right after its last retry_o cycle. A retry with look_busy_i=1 raises no request.
- R5: push_go_o pulses for exactly one cycle: the first cycle in which bus_req_o has been high for at least PUSH_WAIT cycles (default 3) and bus_grant_i=1. A grant while no request is pending gives no strobe.
- R6: bus_req_o stays high from its rise up to and including the push_go_o cycle, and is low in the next cycle.
- R7: From the decision that needs a push until push_go_o, every new address start is retried with R2/R3 timing whatever the lookup returns, and adds no second push.
- R8: While rst_n=0 at a clock edge, retry_o, bus_req_o and push_go_o are low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| snp_ts_i | input | 1 | Address start of a snooped tenure by another master |
| snp_aack_i | input | 1 | Address acknowledge, one cycle |
| bus_grant_i | input | 1 | Bus grant to this agent |
| look_hit_i | input | 1 | Lookup stub: address present in cache (valid with snp_ts_i) |
| look_dirty_i | input | 1 | Lookup stub: line is modified (valid with snp_ts_i) |
| look_busy_i | input | 1 | Lookup stub: snoop cannot be serviced now (valid with snp_ts_i) |
| retry_o | output | 1 | Address retry response |
| bus_req_o | output | 1 | Bus request for the copy-back |
| push_go_o | output | 1 | One-cycle strobe that starts the copy-back tenure |

## Verification
The hardest state to reach is a second snooped tenure that arrives while a copy-back is owed but not yet granted. The retry for that tenure must come from the pending push and not from the lookup, and the request must be left untouched. The bench gets there by running a dirty-hit tenure and holding the grant back. It then issues further tenures with miss and dirty lookups, and grants only after those have been acknowledged. Two more edges are covered: an acknowledge in the decision cycle, which gives a retry of a single cycle, and a grant at the exact end of the wait window.

// File: rtl/snp_pkg.sv
// Shared types and lookup decode for the snoop retry generator.
// Assumes: lookup flags are active-high and valid together.
package snp_pkg;

    typedef struct packed {
        logic hit;
        logic dirty;
        logic busy;
    } snp_look_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ASSERT,
        ST_HOLD
    } snp_state_e;

    // Retry is owed for a dirty hit or for a lookup that cannot be served.
    function automatic logic snp_need(input snp_look_t r);
        return r.busy | (r.hit & r.dirty);
    endfunction

    // Copy-back is owed only for a serviceable dirty hit.
    function automatic logic snp_push(input snp_look_t r);
        return r.hit & r.dirty & ~r.busy;
    endfunction

endpackage

// File: rtl/snp_lookup_stub.sv
// Stand-in for the tag lookup: returns the flags sampled at address start
// LAT cycles later, with a valid strobe. LAT=0 passes them through.
// Assumes: flags are presented in the same cycle as the address start.
module snp_lookup_stub
    import snp_pkg::*;
#(
    parameter int LAT = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ts_i,
    input  snp_look_t look_i,
    output logic      res_vld_o,
    output snp_look_t res_o
);

    generate
        if (LAT == 0) begin : g_direct
            assign res_vld_o = ts_i;
            assign res_o     = look_i;
        end else begin : g_pipe
            logic      vld_q [LAT];
            snp_look_t dat_q [LAT];

            // Delay line carrying the sampled flags toward the decision.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < LAT; i++) begin
                        vld_q[i] <= 1'b0;
                        dat_q[i] <= '0;
                    end
                end else begin
                    vld_q[0] <= ts_i;
                    dat_q[0] <= look_i;
                    for (int i = 1; i < LAT; i++) begin
                        vld_q[i] <= vld_q[i-1];
                        dat_q[i] <= dat_q[i-1];
                    end
                end
            end

            assign res_vld_o = vld_q[LAT-1];
            assign res_o     = dat_q[LAT-1];
        end
    endgenerate

endmodule

// File: rtl/snp_retry_ctl.sv
// Per-tenure retry sequencer. Waits in WAIT from the cycle after address
// start until a decision is known, drives retry from the next cycle, and
// holds it through the cycle after acknowledge.
// Assumes: one snooped tenure at a time; acknowledge not before decision.
module snp_retry_ctl
    import snp_pkg::*;
#(
    parameter bit SAME_CYCLE = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ts_i,
    input  logic      aack_i,
    input  logic      res_vld_i,
    input  snp_look_t res_i,
    input  logic      pending_i,
    output logic      retry_o,
    output logic      arm_o,
    output logic      qual_o
);

    snp_state_e state_q;
    logic       known_q, need_q, push_q, retry_q;
    logic       res_need, res_push, cur_known, cur_need, cur_push, idle_take;

    // Merge a freshly arrived lookup result with one captured earlier.
    always_comb begin
        res_need  = snp_need(res_i);
        res_push  = snp_push(res_i);
        cur_known = known_q | res_vld_i;
        cur_need  = known_q ? need_q : res_need;
        cur_push  = known_q ? push_q : res_push;
        idle_take = SAME_CYCLE & res_vld_i;
    end

    assign arm_o   = (state_q == ST_WAIT) & cur_known & cur_need & cur_push;
    assign qual_o  = (state_q == ST_HOLD) & push_q;
    assign retry_o = retry_q;

    // Tenure state machine and retry register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            known_q <= 1'b0;
            need_q  <= 1'b0;
            push_q  <= 1'b0;
            retry_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (ts_i) begin
                        state_q <= ST_WAIT;
                        known_q <= pending_i | idle_take;
                        need_q  <= pending_i | (idle_take & res_need);
                        push_q  <= ~pending_i & idle_take & res_push;
                    end
                end
                ST_WAIT: begin
                    if (cur_known) begin
                        known_q <= 1'b1;
                        push_q  <= cur_push & cur_need;
                        if (cur_need) begin
                            retry_q <= 1'b1;
                            state_q <= aack_i ? ST_HOLD : ST_ASSERT;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_ASSERT: begin
                    if (aack_i) state_q <= ST_HOLD;
                end
                default: begin
                    retry_q <= 1'b0;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    AST_RETRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_o && aack_i) |=> retry_o); // R3

    AST_RETRY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(retry_o) |-> $past(aack_i, 2)); // R3

endmodule

// File: rtl/snp_push_req.sv
// Copy-back bus request: holds the pending-push flag from decision to
// push start, raises the request after the qualified retry, and accepts a
// grant only after PUSH_WAIT cycles of request.
// Assumes: the arbiter keeps granting until it sees the push start.
module snp_push_req #(
    parameter int PUSH_WAIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic qual_i,
    input  logic bg_i,
    output logic pending_o,
    output logic req_o,
    output logic go_o
);

    localparam int CW = $clog2(PUSH_WAIT + 2);
    localparam logic [CW-1:0] WAIT_END = CW'(PUSH_WAIT);

    logic          pend_q, req_q;
    logic [CW-1:0] cnt_q;

    assign go_o      = req_q & bg_i & (cnt_q >= WAIT_END);
    assign req_o     = req_q;
    assign pending_o = pend_q;

    // Pending flag and request, both cleared by the push start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            req_q  <= 1'b0;
        end else if (go_o) begin
            pend_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            if (arm_i)  pend_q <= 1'b1;
            if (qual_i) req_q  <= 1'b1;
        end
    end

    // Saturating count of cycles spent requesting.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_q) cnt_q <= '0;
        else if (cnt_q != WAIT_END) cnt_q <= cnt_q + 1'b1;
    end

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |=> !req_o); // R6

endmodule

// File: rtl/snoop_retry_gen.sv
// Top of the snoop retry generator: lookup stub, tenure sequencer and
// copy-back request, wired together.
// Assumes: active-high bus signals; no new address start before the
// second cycle after an acknowledge.
module snoop_retry_gen
    import snp_pkg::*;
#(
    parameter int LOOKUP_LAT = 1,
    parameter int PUSH_WAIT  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic snp_ts_i,
    input  logic snp_aack_i,
    input  logic bus_grant_i,
    input  logic look_hit_i,
    input  logic look_dirty_i,
    input  logic look_busy_i,
    output logic retry_o,
    output logic bus_req_o,
    output logic push_go_o
);

    snp_look_t look, res;
    logic      res_vld, pending, arm, qual;

    assign look = '{hit: look_hit_i, dirty: look_dirty_i, busy: look_busy_i};

    snp_lookup_stub #(.LAT(LOOKUP_LAT)) u_look (
        .clk(clk), .rst_n(rst_n), .ts_i(snp_ts_i), .look_i(look),
        .res_vld_o(res_vld), .res_o(res)
    );

    snp_retry_ctl #(.SAME_CYCLE(LOOKUP_LAT == 0)) u_ctl (
        .clk(clk), .rst_n(rst_n), .ts_i(snp_ts_i), .aack_i(snp_aack_i),
        .res_vld_i(res_vld), .res_i(res), .pending_i(pending),
        .retry_o(retry_o), .arm_o(arm), .qual_o(qual)
    );

    snp_push_req #(.PUSH_WAIT(PUSH_WAIT)) u_push (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .qual_i(qual),
        .bg_i(bus_grant_i), .pending_o(pending), .req_o(bus_req_o),
        .go_o(push_go_o)
    );

    AST_RETRY_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retry_o) |-> (!snp_ts_i && !$past(snp_ts_i))); // R2

    AST_REQ_AFTER_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req_o) |-> ($past(retry_o) && !retry_o)); // R4

    AST_REQ_UNTIL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !push_go_o) |=> bus_req_o); // R6

endmodule

// File: tb/snoop_retry_gen_tb.sv
// Bench: a behavioural reference fills per-cycle expectation arrays from
// the requirements; every cycle the outputs are compared on the falling edge.
module snoop_retry_gen_tb;

    localparam int LAT   = 1;
    localparam int PWAIT = 3;
    localparam int MAXC  = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ts = 1'b0, aack = 1'b0, bg = 1'b0;
    logic hit = 1'b0, dirty = 1'b0, busy = 1'b0;
    logic retry, req, go;

    logic exp_r [MAXC];
    logic exp_q [MAXC];
    logic exp_g [MAXC];

    int    cyc = 0;
    int    nchk = 0, nerr = 0;
    bit    checking = 1'b0, done = 1'b0;
    bit    pend_m = 1'b0;
    int    req_start = 0;
    string cur_tag = "R8";

    always #10 clk = ~clk;

    snoop_retry_gen #(.LOOKUP_LAT(LAT), .PUSH_WAIT(PWAIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .snp_ts_i(ts), .snp_aack_i(aack),
        .bus_grant_i(bg), .look_hit_i(hit), .look_dirty_i(dirty),
        .look_busy_i(busy), .retry_o(retry), .bus_req_o(req), .push_go_o(go)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Compare all outputs against the reference every cycle.
    always @(negedge clk) begin
        if (checking && !done && cyc < MAXC) begin
            nchk++;
            if (retry !== exp_r[cyc] || req !== exp_q[cyc] || go !== exp_g[cyc]) begin
                nerr++;
                $display("FAIL %s cycle %0d retry/req/go actual %b%b%b expected %b%b%b",
                         cur_tag, cyc, retry, req, go, exp_r[cyc], exp_q[cyc], exp_g[cyc]);
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        if (!done && cyc > 20000) begin
            done = 1'b1;
            nerr++;
            $display("FAIL watchdog actual cycle %0d expected below 20000", cyc);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // One snooped tenure; reference: R1 decides, R2/R3 time, R4/R7 push.
    task automatic tenure(input bit h, input bit d, input bit b,
                          input int ack_off, input string tag);
        int  t0, a, rise;
        bit  need, psh;
        cur_tag = tag;
        t0   = cyc;
        a    = t0 + ack_off;
        rise = t0 + ((LAT + 1 > 2) ? LAT + 1 : 2);
        need = pend_m | b | (h & d);
        psh  = !pend_m & h & d & !b;
        if (need) for (int k = rise; k <= a + 1; k++) exp_r[k] = 1'b1;
        if (psh) begin
            pend_m    = 1'b1;
            req_start = a + 2;
            for (int k = a + 2; k < MAXC; k++) exp_q[k] = 1'b1;
        end
        ts = 1'b1; hit = h; dirty = d; busy = b;
        step();
        ts = 1'b0; hit = 1'b0; dirty = 1'b0; busy = 1'b0;
        while (cyc < a) step();
        aack = 1'b1;
        step();
        aack = 1'b0;
        step();
        step();
    endtask

    // Grant the copy-back request; reference from R5 and R6.
    task automatic grant(input int dly, input string tag);
        int bgs, g;
        cur_tag = tag;
        while (cyc < req_start + dly) step();
        bgs = cyc;
        g   = (bgs > req_start + PWAIT) ? bgs : req_start + PWAIT;
        exp_g[g] = 1'b1;
        for (int k = g + 1; k < MAXC; k++) exp_q[k] = 1'b0;
        bg = 1'b1;
        while (cyc <= g) step();
        bg = 1'b0;
        pend_m = 1'b0;
        step();
        step();
    endtask

    initial begin
        for (int k = 0; k < MAXC; k++) begin
            exp_r[k] = 1'b0; exp_q[k] = 1'b0; exp_g[k] = 1'b0;
        end
        @(posedge clk);
        #2;
        checking = 1'b1;          // R8: outputs low while reset is held
        step(); step();
        rst_n = 1'b1;
        step(); step();

        tenure(1'b0, 1'b0, 1'b0, 3, "R1 miss");
        tenure(1'b1, 1'b0, 1'b0, 2, "R1 clean hit");
        tenure(1'b0, 1'b0, 1'b1, 4, "R1 R2 R3 busy no push R4");
        tenure(1'b1, 1'b1, 1'b1, 3, "R4 busy dirty no push");
        tenure(1'b1, 1'b1, 1'b0, 1, "R3 aack in decision cycle R4");
        grant(0, "R5 grant at window end R6");

        cur_tag = "R5 grant without request";
        bg = 1'b1;
        repeat (4) step();
        bg = 1'b0;
        step();

        tenure(1'b1, 1'b1, 1'b0, 5, "R2 R3 long hold R4");
        tenure(1'b0, 1'b0, 1'b0, 2, "R7 forced on miss");
        tenure(1'b1, 1'b1, 1'b0, 3, "R7 forced on dirty no second push");
        grant(16, "R5 late grant R6");
        tenure(1'b1, 1'b1, 1'b0, 2, "R4 push after release");
        grant(5, "R5 R6 second push");
        tenure(1'b0, 1'b0, 1'b0, 2, "R7 pending cleared");
        repeat (4) step();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule